// File: doc/BRIEF.md
# Configuration Record Scanner with Station Address Check

The block walks a region of non-volatile configuration storage one 32-bit word at a time. It uses a request/response read port whose far side may be an EEPROM path or a flash path. The stored data is a chain of two-word records. A marker word names a target register, and the word after it holds the value for that register. The scanner keeps the values meant for the two registers that hold the 48-bit station address and drops all others. The walk ends at the first word that is neither a marker nor a pending value.

When the walk ends, the recovered address is presented on `station_addr` with byte 0 in the top byte. A validity flag rejects the all-zero address and any group address (multicast or broadcast). A one-cycle `done` pulse marks the end of the scan. The same end is reached when a read reports an error, when no response arrives within a parameterised number of cycles, or when the start address is not word aligned. In each of these cases the result is built from whatever was recovered before the failure.

Top module: `cfg_record_scanner`

## Requirements
- R1: A `start` pulse while idle latches `base_addr` (a byte address) and issues reads at `base_addr`, `base_addr+4`, `base_addr+8`, ... with one read outstanding at a time. Each read is a single-cycle `rd_req`.
- R2: With no marker pending, a word whose bits [7:0] equal 0x5A is a marker. Its bits [31:16] give the target register offset for the next word.
- R3: The word read right after a marker is a value for that offset, whatever its content. The pending marker is then cleared, so a value word whose low byte is 0x5A is not taken as a marker.
- R4: With no marker pending, a word whose bits [7:0] differ from 0x5A ends the scan. No further read is issued.
- R5: A response with `rd_err` high ends the scan. A missing response also ends it: `rd_ack` must arrive within `TIMEOUT` cycles, counting the request cycle as the first.
- R6: A value for offset `STA_OFS` is stored as the low address word, and a value for `STA_OFS+4` as the high address word. Values for any other offset change nothing. A later record for the same offset replaces the earlier one.
- R7: `station_addr[47:32]` is high-word bits [15:0] and `station_addr[31:0]` is the low word. Address byte 0 (the first transmitted byte) is `station_addr[47:40]`, and byte 5 is `station_addr[7:0]`.
- R8: `addr_valid` is 0 when all 48 address bits are zero or when bit 0 of byte 0 (`station_addr[40]`) is set. Otherwise it is 1.
- R9: A base address with bits [1:0] not zero counts as a failed read. The scan ends without any `rd_req`.
- R10: Both address words clear to zero when a scan starts, and at reset. A scan that finds no address record therefore reports the all-zero, invalid address.
- R11: `busy` is high from the cycle after an accepted `start` until the scan ends. `done` is high for exactly one cycle at the end. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (pulse) |
| base_addr | input | ADDR_W | Byte address of the first word |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| addr_valid | output | 1 | Recovered address is a usable unicast address |
| station_addr | output | 48 | Recovered address, byte 0 in bits [47:40] |
| rd_req | output | 1 | Single-cycle read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_ack | input | 1 | Read response strobe |
| rd_err | input | 1 | Response is a failure (valid with rd_ack) |
| rd_data | input | 32 | Read data (valid with rd_ack) |

## Verification
The scanner is driven with several kinds of directed record chains:

- Both address records in forward order, and both in reverse order. These show the record routing is by offset, not by position.
- Chains mixed with foreign offsets and with value words that carry the marker byte. These separate marker decoding from value capture.
- Chains with a repeated offset, which expose last-writer ordering.
- An empty chain and a group address. These check the two rejection rules of the validity test on their own.

Port faults come next:

- An error on a mid-chain read and a response one cycle too late. Each should keep exactly the data recovered before it. A response one cycle earlier must still be accepted.
- A misaligned base, which must end the scan with no read at all.

Random record chains at both base addresses fill in the remaining combinations. Throughout, the request address sequence and the read count are compared with a reference walk, so an early or late stop is caught even when the address happens to match.

// File: rtl/cfg_scan_pkg.sv
// Shared types and constants for the configuration record scanner.
// Assumes: 32-bit storage words, 48-bit station address.
package cfg_scan_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned STA_W    = 48;
    localparam logic [7:0]  KEY_BYTE = 8'h5A;

    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_WAIT  = 2'd2,
        SC_FIN   = 2'd3
    } scan_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } sta_words_t;

endpackage

// File: rtl/cfg_read_engine.sv
// Read engine: issues one single-cycle word read per 'go' and waits for the reply.
// It reports either resp_ok with the data, or resp_fail. A failure is an error
// reply, no reply within TIMEOUT cycles (the request cycle counts as the first),
// or a misaligned address, which is rejected without a request.
// Assumes: 'go' is only raised when no read is outstanding.
module cfg_read_engine #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic [31:0]       rd_data,
    output logic              resp_ok,
    output logic              resp_fail,
    output logic [31:0]       resp_data
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    logic             waiting;
    logic [CNT_W-1:0] wait_cnt;
    logic             misaligned;

    assign misaligned = (addr_in[1:0] != 2'b00);

    // Request issue, response capture and timeout counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req    <= 1'b0;
            rd_addr   <= '0;
            waiting   <= 1'b0;
            wait_cnt  <= '0;
            resp_ok   <= 1'b0;
            resp_fail <= 1'b0;
            resp_data <= '0;
        end else begin
            rd_req    <= 1'b0;
            resp_ok   <= 1'b0;
            resp_fail <= 1'b0;
            if (go) begin
                if (misaligned) begin
                    resp_fail <= 1'b1;
                end else begin
                    rd_req   <= 1'b1;
                    rd_addr  <= addr_in;
                    waiting  <= 1'b1;
                    wait_cnt <= '0;
                end
            end else if (waiting) begin
                if (rd_ack) begin
                    waiting <= 1'b0;
                    if (rd_err) begin
                        resp_fail <= 1'b1;
                    end else begin
                        resp_ok   <= 1'b1;
                        resp_data <= rd_data;
                    end
                end else if (wait_cnt == CNT_LAST) begin
                    waiting   <= 1'b0;
                    resp_fail <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_rec_decoder.sv
// Record decoder: classifies each returned word as a marker, a value or an end
// marker, and keeps the two station-address words.
// Assumes: 'clr' and 'word_vld' are never high in the same cycle.
module cfg_rec_decoder
    import cfg_scan_pkg::*;
#(
    parameter logic [15:0] STA_OFS = 16'h0140
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        word_vld,
    input  logic [31:0] word,
    output logic        end_of_data,
    output sta_words_t  sta_words
);
    localparam logic [15:0] STA_OFS_HI = STA_OFS + 16'd4;

    logic        pend;
    logic [15:0] pend_ofs;
    logic        is_key;

    assign is_key      = (word[7:0] == KEY_BYTE);
    assign end_of_data = word_vld && !pend && !is_key;

    // Marker tracking and capture of the two address words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_ofs  <= '0;
            sta_words <= '0;
        end else if (clr) begin
            pend      <= 1'b0;
            sta_words <= '0;
        end else if (word_vld) begin
            if (pend) begin
                if (pend_ofs == STA_OFS) begin
                    sta_words.lo <= word;
                end else if (pend_ofs == STA_OFS_HI) begin
                    sta_words.hi <= word;
                end
                pend <= 1'b0;
            end else if (is_key) begin
                pend     <= 1'b1;
                pend_ofs <= word[31:16];
            end
        end
    end

endmodule

// File: rtl/cfg_addr_check.sv
// Address assembly and check: places byte 0 in the top byte and flags all-zero
// or group addresses as invalid. Purely combinational.
module cfg_addr_check
    import cfg_scan_pkg::*;
(
    input  sta_words_t         sta_words,
    output logic [STA_W-1:0]   station_addr,
    output logic               addr_valid
);
    localparam int unsigned NBYTES = STA_W / 8;

    logic [NBYTES-1:0] byte_nz;

    assign station_addr = {sta_words.hi[15:0], sta_words.lo};

    // One non-zero detector per address byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_nz
        assign byte_nz[b] = |station_addr[8*b +: 8];
    end

    // Byte 0 sits in [47:40]; its bit 0 is the group bit.
    assign addr_valid = (|byte_nz) && !station_addr[STA_W-8];

endmodule

// File: rtl/cfg_record_scanner.sv
// Top of the configuration record scanner. A sequencer steps the read engine
// through storage, feeds each word to the record decoder, and ends on an end
// marker or a failed read.
// Assumes: start is a pulse; the storage side answers each request at most once.
module cfg_record_scanner
    import cfg_scan_pkg::*;
#(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned TIMEOUT = 16,
    parameter logic [15:0] STA_OFS = 16'h0140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              busy,
    output logic              done,
    output logic              addr_valid,
    output logic [47:0]       station_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic              rd_err,
    input  logic [31:0]       rd_data
);
    scan_state_t       state;
    logic [ADDR_W-1:0] cur_addr;
    logic              accept;
    logic              go;
    logic              resp_ok;
    logic              resp_fail;
    logic [31:0]       resp_data;
    logic              end_of_data;
    sta_words_t        sta_words;

    assign accept = (state == SC_IDLE) && start;
    assign go     = (state == SC_ISSUE);
    assign busy   = (state != SC_IDLE);
    assign done   = (state == SC_FIN);

    // Scan sequencer: issue, wait, decide to continue or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SC_IDLE;
            cur_addr <= '0;
        end else begin
            unique case (state)
                SC_IDLE: begin
                    if (start) begin
                        cur_addr <= base_addr;
                        state    <= SC_ISSUE;
                    end
                end
                SC_ISSUE: state <= SC_WAIT;
                SC_WAIT: begin
                    if (resp_fail) begin
                        state <= SC_FIN;
                    end else if (resp_ok) begin
                        if (end_of_data) begin
                            state <= SC_FIN;
                        end else begin
                            cur_addr <= cur_addr + ADDR_W'(4);
                            state    <= SC_ISSUE;
                        end
                    end
                end
                SC_FIN: state <= SC_IDLE;
                default: state <= SC_IDLE;
            endcase
        end
    end

    cfg_read_engine #(
        .ADDR_W  (ADDR_W),
        .TIMEOUT (TIMEOUT)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .addr_in   (cur_addr),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .rd_ack    (rd_ack),
        .rd_err    (rd_err),
        .rd_data   (rd_data),
        .resp_ok   (resp_ok),
        .resp_fail (resp_fail),
        .resp_data (resp_data)
    );

    cfg_rec_decoder #(
        .STA_OFS (STA_OFS)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (accept),
        .word_vld    (resp_ok),
        .word        (resp_data),
        .end_of_data (end_of_data),
        .sta_words   (sta_words)
    );

    cfg_addr_check u_chk (
        .sta_words    (sta_words),
        .station_addr (station_addr),
        .addr_valid   (addr_valid)
    );

endmodule

// File: rtl/cfg_scan_checker.sv
// Protocol checker for the record scanner, attached to every instance by bind.
module cfg_scan_checker #(
    parameter int unsigned ADDR_W  = 24,
    parameter int unsigned TIMEOUT = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack
);
    localparam int unsigned WC_W = $clog2(TIMEOUT + 3);

    logic              seen;
    logic [ADDR_W-1:0] last_addr;
    logic              outst;
    logic [WC_W-1:0]   wcnt;

    // Remember the previous request address within one scan.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            seen      <= 1'b0;
            last_addr <= '0;
        end else if (rd_req) begin
            seen      <= 1'b1;
            last_addr <= rd_addr;
        end
    end

    // Count cycles a request stays unanswered.
    always_ff @(posedge clk) begin
        if (!rst_n || done) begin
            outst <= 1'b0;
            wcnt  <= '0;
        end else if (rd_req) begin
            outst <= 1'b1;
            wcnt  <= WC_W'(1);
        end else if (outst && rd_ack) begin
            outst <= 1'b0;
            wcnt  <= '0;
        end else if (outst) begin
            wcnt <= wcnt + 1'b1;
        end
    end

    // R1
    req_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && seen) |-> (rd_addr == last_addr + ADDR_W'(4)));
    // R1
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outst |-> (wcnt <= WC_W'(TIMEOUT + 1)));
    // R9
    aligned_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind cfg_record_scanner cfg_scan_checker #(
    .ADDR_W  (ADDR_W),
    .TIMEOUT (TIMEOUT)
) u_scan_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .rd_ack  (rd_ack)
);

// File: tb/sim_cfg_record_scanner.sv
module sim_cfg_record_scanner;
    localparam int unsigned ADDR_W  = 24;
    localparam int unsigned TIMEOUT = 16;
    localparam logic [15:0] STA_OFS = 16'h0140;
    localparam int          NMEM    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic              busy, done, addr_valid;
    logic [47:0]       station_addr;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic              rd_err = 1'b0;
    logic [31:0]       rd_data = '0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0]       mem [NMEM];
    logic [ADDR_W-1:0] mem_base = '0;
    int                lat      = 2;
    int                err_idx  = -1;

    logic              m_act  = 1'b0;
    int                m_left = 0;
    logic [ADDR_W-1:0] m_addr = '0;

    int                n_req  = 0;
    int                n_bad  = 0;
    logic [ADDR_W-1:0] exp_next = '0;

    cfg_record_scanner #(
        .ADDR_W  (ADDR_W),
        .TIMEOUT (TIMEOUT),
        .STA_OFS (STA_OFS)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .base_addr (base_addr),
        .busy (busy), .done (done), .addr_valid (addr_valid),
        .station_addr (station_addr), .rd_req (rd_req), .rd_addr (rd_addr),
        .rd_ack (rd_ack), .rd_err (rd_err), .rd_data (rd_data)
    );

    always #2 clk = ~clk;

    function automatic int widx(input logic [ADDR_W-1:0] a);
        int d;
        d = int'(a) - int'(mem_base);
        if (d < 0 || (d % 4) != 0 || d / 4 >= NMEM) return -1;
        return d / 4;
    endfunction

    // Storage model: answers lat+1 cycles after the request cycle.
    always @(posedge clk) begin
        rd_ack <= 1'b0;
        rd_err <= 1'b0;
        if (rd_req) begin
            m_act  <= 1'b1;
            m_left <= (lat < 1) ? 0 : lat - 1;
            m_addr <= rd_addr;
        end else if (m_act) begin
            if (m_left == 0) begin
                m_act  <= 1'b0;
                rd_ack <= 1'b1;
                rd_err <= (widx(m_addr) == err_idx) && (err_idx >= 0);
                rd_data <= (widx(m_addr) < 0) ? 32'h0 : mem[widx(m_addr)];
            end else begin
                m_left <= m_left - 1;
            end
        end
    end

    // Request observer: address sequence and count (R1).
    always @(negedge clk) begin
        if (rd_req) begin
            if (rd_addr != exp_next) n_bad++;
            exp_next = exp_next + ADDR_W'(4);
            n_req++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference walk over the storage image.
    task automatic ref_scan(input logic [ADDR_W-1:0] base,
                            output logic [47:0] ea, output bit ev, output int nr);
        logic [31:0] lo, hi, w;
        bit          pend;
        logic [15:0] ofs;
        lo = 0; hi = 0; pend = 0; ofs = 0; nr = 0;
        if (base[1:0] == 2'b00) begin
            for (int i = 0; i < 4 * NMEM; i++) begin
                nr++;
                if (i == err_idx || lat + 1 > TIMEOUT - 1) break;
                w = (i < NMEM) ? mem[i] : 32'h0;
                if (pend) begin
                    if (ofs == STA_OFS) lo = w;
                    else if (ofs == STA_OFS + 16'd4) hi = w;
                    pend = 0;
                end else if (w[7:0] == 8'h5A) begin
                    pend = 1; ofs = w[31:16];
                end else break;
            end
        end
        ea = {hi[15:0], lo};
        ev = (ea != 48'h0) && !ea[40];
    endtask

    task automatic clear_mem();
        for (int i = 0; i < NMEM; i++) mem[i] = 32'h0000_0011;
    endtask

    function automatic logic [31:0] key(input logic [15:0] ofs);
        return {ofs, 8'h00, 8'h5A};
    endfunction

    // Run one scan; optionally poke a second start mid-scan.
    task automatic run_scan(input logic [ADDR_W-1:0] base, input string req,
                            input bit poke = 0);
        logic [47:0] ea; bit ev; int nr; int cyc; int ndone;
        ref_scan(base, ea, ev, nr);
        mem_base = {base[ADDR_W-1:2], 2'b00};
        exp_next = base; n_req = 0; n_bad = 0; ndone = 0;
        @(negedge clk);
        base_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", "busy after start", 64'(busy), 64'd1);
        cyc = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 3) begin
                base_addr = base + ADDR_W'(64); start = 1'b1;
            end else start = 1'b0;
        end
        start = 1'b0;
        if (done) ndone++;
        check(done == 1'b1, req, "scan reaches done", 64'(done), 64'd1);
        check(station_addr == ea, req, "station address", 64'(station_addr), 64'(ea));
        check(addr_valid == ev, req, "address validity", 64'(addr_valid), 64'(ev));
        check(n_req == nr, req, "read count", 64'(n_req), 64'(nr));
        check(n_bad == 0, "R1", "request address sequence", 64'(n_bad), 64'd0);
        for (int k = 0; k < 3 * TIMEOUT; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check(ndone == 1 && !busy, "R11", "single done pulse then idle",
              64'(ndone), 64'd1);
        check(station_addr == ea, req, "address held after done",
              64'(station_addr), 64'(ea));
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        clear_mem();
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!busy && !done && !rd_req, "R10", "idle after reset",
              {61'd0, busy, done, rd_req}, 64'd0);
        check(station_addr == 48'h0 && !addr_valid, "R10", "zero invalid at reset",
              64'(station_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R6 R7: both records, forward order, EEPROM base
        clear_mem();
        mem[0] = key(STA_OFS);          mem[1] = 32'h6AF6_00DC;
        mem[2] = key(STA_OFS + 16'd4);  mem[3] = 32'h0000_000B;
        mem[4] = 32'h0000_1234;
        run_scan(24'h000100, "R7");
        check(station_addr == 48'h000B_6AF6_00DC, "R7", "byte order",
              64'(station_addr), 64'h000B_6AF6_00DC);

        // R3 R6: reverse order, foreign offsets, value with marker byte, repeat
        clear_mem();
        mem[0] = key(STA_OFS + 16'd4);  mem[1] = 32'hFFFF_2200;
        mem[2] = key(16'h0200);         mem[3] = 32'h0000_005A;
        mem[4] = key(STA_OFS);          mem[5] = 32'h1111_1111;
        mem[6] = key(STA_OFS);          mem[7] = 32'hA1B2_C35A;
        mem[8] = 32'h0000_0000;
        run_scan(24'h000100, "R3");
        check(station_addr == 48'h2200_A1B2_C35A, "R6", "last writer and ignore",
              64'(station_addr), 64'h2200_A1B2_C35A);

        // R4 R10: first word ends the chain after a prior valid result
        clear_mem();
        mem[0] = 32'h0000_00A5;
        run_scan(24'h000100, "R10");

        // R8: group bit set
        clear_mem();
        mem[0] = key(STA_OFS + 16'd4);  mem[1] = 32'h0000_0100;
        mem[2] = 32'h0;
        run_scan(24'h000100, "R8");

        // R5: error on the fourth read keeps earlier data
        clear_mem();
        mem[0] = key(STA_OFS);          mem[1] = 32'h0102_0304;
        mem[2] = key(STA_OFS + 16'd4);  mem[3] = 32'h0000_0A0B;
        mem[4] = 32'h0;
        err_idx = 3;
        run_scan(24'h000100, "R5");
        err_idx = -1;

        // R5: slowest accepted response, then one cycle too late
        lat = TIMEOUT - 2;
        run_scan(24'h000100, "R5");
        lat = TIMEOUT - 1;
        run_scan(24'h000100, "R5");
        lat = 2;

        // R9: misaligned base
        run_scan(24'h000102, "R9");

        // R11: second start during a scan is ignored; flash base (R1)
        clear_mem();
        mem[0] = key(STA_OFS);          mem[1] = 32'hDEAD_BEEF;
        mem[2] = key(STA_OFS + 16'd4);  mem[3] = 32'h0000_0246;
        mem[4] = 32'h0;
        run_scan(24'h01F000, "R11", 1'b1);

        // Random chains at both bases
        for (int t = 0; t < 40; t++) begin
            int nrec; int p;
            clear_mem();
            nrec = $urandom_range(0, 8);
            p = 0;
            for (int r = 0; r < nrec; r++) begin
                case ($urandom_range(0, 2))
                    0: mem[p] = key(STA_OFS);
                    1: mem[p] = key(STA_OFS + 16'd4);
                    default: mem[p] = key(16'($urandom));
                endcase
                mem[p + 1] = $urandom;
                if ($urandom_range(0, 3) == 0) mem[p + 1][7:0] = 8'h5A;
                if ($urandom_range(0, 3) == 0) mem[p + 1][8] = 1'b0;
                p += 2;
            end
            mem[p] = {$urandom, 8'h00} | 32'h1;
            lat = $urandom_range(1, TIMEOUT - 2);
            run_scan((t % 2 == 0) ? 24'h000100 : 24'h01F000, "R6");
        end
        lat = 2;

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule